// File: doc/BRIEF.md
# Zero-Wait Four-Register Bus Slave

This block is a small peripheral register file that sits on a pipelined system bus in which every transfer has an address phase followed by a data phase. It holds four 32-bit word locations: a control word, a read-only status word, a data word and a configuration word. The status word is not stored. It shows the value on a status input pin at the moment it is read.

The block works in two steps. In the address phase, while the bus-wide ready signal is high, it latches three things: a select that counts only real transfers, the direction of the transfer, and the word index taken from address bits [3:2]. In the next cycle, the data phase, it acts only on that latched context. A write puts the write data into the indexed word. A read routes the indexed word through a combinational multiplexer onto the read data output. The block never stalls and never signals an error, so it holds no state machine. A write to the status word is dropped without any sign on the bus.

Top module: `zw_regslave`

## Requirements
- R1: On a rising clock edge with `bus_ready_in` high, the block latches three values. The select is `bus_sel` AND a real transfer code, where the transfer codes are IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10 and SEQ=2'b11, and NONSEQ and SEQ are the real ones. It also latches `bus_write` and the word index `bus_addr[3:2]`.
- R2: While `bus_ready_in` is low, the latched select, direction and index keep their previous values.
- R3: An IDLE or BUSY transfer changes no register and produces no read data, even when `bus_sel` is high.
- R4: In the data phase, when both the latched select and the latched write flag are set, `bus_wdata` is written into the word chosen by the latched index. Index 0 is control, index 2 is data and index 3 is configuration. The live address and write pins of the next transfer play no part in this write.
- R5: Index 1 is the status word. A write to it is dropped, and later reads still return `status_in`.
- R6: During the data phase of a selected read, `bus_rdata` carries the word chosen by the latched index. This is combinational and takes no extra cycle. Index 1 returns `status_in` as it stands in that cycle.
- R7: `bus_rdata` is all zeros whenever the latched select is low or the latched transfer is a write.
- R8: `bus_ready_out` is 1 and `bus_resp` is 0 (OKAY) on every cycle, including during reset.
- R9: A write followed back-to-back by a read of the same word returns the newly written value in the read's data phase.
- R10: An active-low `rst_n` clears the latched select, direction and index, as well as the control, data and configuration words, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Slave select from the address decoder |
| bus_addr | input | 32 | Byte address; bits [3:2] pick the word |
| bus_trans | input | 2 | Transfer type (IDLE/BUSY/NONSEQ/SEQ) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 3 | Transfer size; all accesses are treated as full words |
| bus_wdata | input | 32 | Write data, valid in the data phase |
| bus_ready_in | input | 1 | Bus-wide ready; high when the current data phase ends |
| status_in | input | 32 | Live value returned for the read-only word |
| bus_rdata | output | 32 | Read data, valid in the data phase |
| bus_ready_out | output | 1 | Transfer-done indication from this slave, always 1 |
| bus_resp | output | 1 | Response, always 0 (OKAY) |

## Verification
Errors in the stored words or in the latched context stay hidden until a read reaches them. The first sign at the ports is a wrong `bus_rdata` in the data phase of the next read of that word, one cycle after its address phase. The bench therefore reads back after each class of write: directed, status-targeted, IDLE/BUSY, stalled capture and live-address hazard. A bad latched select or direction shows up sooner, as nonzero read data in a write or unselected data phase. The bench compares against its reference model on every cycle to catch these.

// File: rtl/regslave_pkg.sv
package regslave_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic RESP_OKAY = 1'b0;

  function automatic logic is_real_transfer(input logic [1:0] code);
    return (code == TR_NONSEQ) || (code == TR_SEQ);
  endfunction

endpackage

// File: rtl/rs_capture.sv
module rs_capture #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_in,
  input  logic             sel,
  input  logic [1:0]       trans,
  input  logic             write,
  input  logic [IDX_W-1:0] idx,
  output logic             sel_q,
  output logic             write_q,
  output logic [IDX_W-1:0] idx_q
);
  import regslave_pkg::*;

  logic qual_sel;
  assign qual_sel = sel & is_real_transfer(trans);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      write_q <= 1'b0;
      idx_q   <= '0;
    end else if (ready_in) begin
      sel_q   <= qual_sel;
      write_q <= write;
      idx_q   <= idx;
    end
  end
endmodule

// File: rtl/rs_regfile.sv
module rs_regfile #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 2,
  parameter int RO_IDX   = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [DATA_W-1:0]                status_in,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    if (g == RO_IDX) begin : g_ro
      assign regs[g] = status_in;
    end else begin : g_rw
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs[g] <= '0;
        else if (hit) regs[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rs_readmux.sv
module rs_readmux #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 2
) (
  input  logic                            sel_q,
  input  logic                            write_q,
  input  logic [IDX_W-1:0]                idx_q,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]               rdata
);
  always_comb begin
    rdata = '0;
    if (sel_q && !write_q) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (idx_q == IDX_W'(i)) rdata = regs[i];
      end
    end
  end
endmodule

// File: rtl/zw_regslave.sv
module zw_regslave #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int IDX_LO   = 2,
  parameter int RO_IDX   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_trans,
  input  logic              bus_write,
  input  logic [2:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready_in,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready_out,
  output logic              bus_resp
);
  import regslave_pkg::*;

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [IDX_W-1:0]                 addr_idx;
  logic                             cap_sel;
  logic                             cap_write;
  logic [IDX_W-1:0]                 cap_idx;
  logic [NUM_REGS-1:0][DATA_W-1:0]  word_q;
  logic                             unused_bits;

  assign addr_idx    = bus_addr[IDX_LO +: IDX_W];
  assign unused_bits = ^{bus_size, bus_addr};

  rs_capture #(.IDX_W(IDX_W)) cap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready_in (bus_ready_in),
    .sel      (bus_sel),
    .trans    (bus_trans),
    .write    (bus_write),
    .idx      (addr_idx),
    .sel_q    (cap_sel),
    .write_q  (cap_write),
    .idx_q    (cap_idx)
  );

  rs_regfile #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .RO_IDX   (RO_IDX)
  ) rf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cap_sel & cap_write),
    .wr_idx    (cap_idx),
    .wr_data   (bus_wdata),
    .status_in (status_in),
    .regs      (word_q)
  );

  rs_readmux #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) rm_i (
    .sel_q   (cap_sel),
    .write_q (cap_write),
    .idx_q   (cap_idx),
    .regs    (word_q),
    .rdata   (bus_rdata)
  );

  assign bus_ready_out = 1'b1;
  assign bus_resp      = RESP_OKAY;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2,
  parameter int RO_IDX   = 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_sel,
  input logic [1:0]                      bus_trans,
  input logic                            bus_ready_in,
  input logic [DATA_W-1:0]               bus_wdata,
  input logic [DATA_W-1:0]               status_in,
  input logic [DATA_W-1:0]               bus_rdata,
  input logic                            sel_q,
  input logic                            write_q,
  input logic [IDX_W-1:0]                idx_q,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  logic [NUM_REGS-1:0][DATA_W-1:0] stored_view;
  always_comb begin
    stored_view = regs;
    stored_view[RO_IDX] = '0;
  end

  assert_idle_busy_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready_in && bus_sel && !bus_trans[1]) |=> !sel_q);

  assert_hold_ctx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready_in |=> ($stable(sel_q) && $stable(write_q) && $stable(idx_q)));

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && write_q && (idx_q != IDX_W'(RO_IDX)))
      |=> (regs[$past(idx_q)] == $past(bus_wdata)));

  assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_q && write_q) |=> $stable(stored_view));

  assert_status_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !write_q && (idx_q == IDX_W'(RO_IDX))) |-> (bus_rdata == status_in));

  assert_quiet_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q || write_q) |-> (bus_rdata == '0));
endmodule

bind zw_regslave rs_checker #(
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W),
  .RO_IDX   (RO_IDX)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_trans    (bus_trans),
  .bus_ready_in (bus_ready_in),
  .bus_wdata    (bus_wdata),
  .status_in    (status_in),
  .bus_rdata    (bus_rdata),
  .sel_q        (cap_sel),
  .write_q      (cap_write),
  .idx_q        (cap_idx),
  .regs         (word_q)
);

// File: tb/zw_regslave_tb_top.sv
`timescale 1ns/1ps
module zw_regslave_tb_top;
  localparam logic [1:0] IDL = 2'b00, BSY = 2'b01, NSQ = 2'b10, SQ = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_trans = IDL;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_size = 3'd2;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready_in = 1'b1;
  logic [31:0] status_in = 32'h0;
  logic [31:0] bus_rdata;
  logic        bus_ready_out;
  logic        bus_resp;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  zw_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_trans(bus_trans), .bus_write(bus_write), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_ready_in(bus_ready_in), .status_in(status_in),
    .bus_rdata(bus_rdata), .bus_ready_out(bus_ready_out), .bus_resp(bus_resp)
  );

  // Behavioural reference: one pending transfer ticket and a word store.
  bit          t_real;
  bit          t_wr;
  int          t_word;
  logic [31:0] store [0:3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_real <= 0; t_wr <= 0; t_word <= 0;
      for (int k = 0; k < 4; k++) store[k] <= '0;
    end else begin
      if (t_real && t_wr && t_word != 1) store[t_word] <= bus_wdata;
      if (bus_ready_in) begin
        t_real <= bus_sel && (bus_trans == NSQ || bus_trans == SQ);
        t_wr   <= bus_write;
        t_word <= int'(bus_addr[3:2]);
      end
    end
  end

  function automatic logic [31:0] model_rdata();
    if (!t_real || t_wr) return 32'h0;
    if (t_word == 1) return status_in;
    return store[t_word];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R6, R7, R8).
  always @(negedge clk) begin
    if (!done) begin
      chk(bus_rdata == model_rdata(), "R6/R7 rdata", bus_rdata, model_rdata());
      chk(bus_ready_out == 1'b1 && bus_resp == 1'b0, "R8 ready/resp",
          {30'd0, bus_ready_out, bus_resp}, 32'h2);
    end
  end

  task automatic beat(input logic s, input logic [1:0] t, input logic w,
                      input logic [31:0] a, input logic [31:0] wd, input logic rdy);
    bus_sel = s; bus_trans = t; bus_write = w; bus_addr = a;
    bus_wdata = wd; bus_ready_in = rdy;
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic [31:0] exp, input string req);
    @(negedge clk);
    chk(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(bus_rdata == 32'h0, "R10 rdata in reset", bus_rdata, 32'h0);
    chk(bus_ready_out == 1'b1 && bus_resp == 1'b0, "R8 in reset",
        {30'd0, bus_ready_out, bus_resp}, 32'h2);
    rst_n = 1'b1;
    status_in = 32'h0000_1234;
    @(negedge clk);

    // R10: words read zero after reset
    beat(1, NSQ, 0, 32'h0, 0, 1); peek(32'h0, "R10 control after reset");
    beat(1, NSQ, 0, 32'h8, 0, 1); peek(32'h0, "R10 data after reset");
    beat(1, NSQ, 0, 32'hC, 0, 1); peek(32'h0, "R10 config after reset");

    // R9/R7: write then back-to-back read of control
    beat(1, NSQ, 1, 32'h0, 0, 1); peek(32'h0, "R7 rdata zero in write data phase");
    beat(1, NSQ, 0, 32'h0, 32'hA5A5_0001, 1); peek(32'hA5A5_0001, "R9 control readback");

    // R1: SEQ writes also select
    beat(1, SQ, 1, 32'h8, 0, 1);
    beat(1, SQ, 1, 32'hC, 32'hDA7A_0002, 1);
    beat(1, SQ, 0, 32'h8, 32'hC0F1_0003, 1); peek(32'hDA7A_0002, "R1 data via SEQ");
    beat(1, NSQ, 0, 32'hC, 0, 1); peek(32'hC0F1_0003, "R6 config readback");

    // R5/R6: status word
    beat(1, NSQ, 0, 32'h4, 0, 1); peek(32'h0000_1234, "R6 status read");
    beat(1, NSQ, 1, 32'h4, 0, 1);
    beat(1, NSQ, 0, 32'h4, 32'hFFFF_FFFF, 1); peek(32'h0000_1234, "R5 status write dropped");
    @(posedge clk); #1 status_in = 32'h0BAD_F00D;
    beat(1, NSQ, 0, 32'h4, 0, 1); peek(32'h0BAD_F00D, "R6 status live");

    // R3: IDLE and BUSY with select high
    beat(1, IDL, 1, 32'h0, 0, 1);
    beat(1, BSY, 1, 32'h0, 32'h1111_1111, 1); peek(32'h0, "R3 no read data on BUSY");
    beat(1, NSQ, 0, 32'h0, 32'h2222_2222, 1); peek(32'hA5A5_0001, "R3 control untouched");

    // R4: live address of next transfer must not steer the write
    beat(1, NSQ, 1, 32'h0, 0, 1);
    beat(0, NSQ, 1, 32'h8, 32'h5EED_0004, 1);
    beat(1, NSQ, 0, 32'h8, 32'h9999_9999, 1); peek(32'hDA7A_0002, "R4 data untouched");
    beat(1, NSQ, 0, 32'h0, 0, 1); peek(32'h5EED_0004, "R4 control written");

    // R2: stalled address phase is not captured until ready
    beat(0, NSQ, 0, 32'h0, 0, 1);
    beat(1, NSQ, 1, 32'hC, 32'h7777_7777, 0); peek(32'h0, "R2 no capture while stalled");
    beat(1, NSQ, 1, 32'hC, 32'h6666_6666, 1);
    beat(1, NSQ, 0, 32'hC, 32'h0FF1_0005, 1); peek(32'h0FF1_0005, "R2 config after stall");

    // R9: alternating write/read on data word
    for (int i = 0; i < 8; i++) begin
      beat(1, NSQ, 1, 32'h8, 0, 1);
      beat(1, NSQ, 0, 32'h8, 32'h1000_0000 + i, 1);
      peek(32'h1000_0000 + i, "R9 data loop");
    end

    beat(0, IDL, 0, 32'h0, 0, 1);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule